// File: doc/BRIEF.md
# Reference Clock Source Selector

This block picks one timing reference for a node out of a fixed pool of candidates. Slots 0 and 1 hold two external station clocks, the slots after them hold recovered line clocks, and the last slot is the node's local oscillator. Each candidate brings a valid flag, a software-set priority and a status byte. The low nibble of the status byte is a 4-bit quality code. The high nibble is a 4-bit identifier of the clock origin.

The block makes a registered decision on every system clock. It reports the index of the winner, the winner's quality code, and a one-cycle strobe whenever the index moves. It has three automatic rules. Priority-only uses just the priority. Quality-first ranks the quality codes through a configurable 16-entry rank table and breaks ties on priority. Extended behaves like quality-first, and in addition it rejects any source that carries the node's own identifier.

Two operator commands take precedence over the automatic rules. A manual request is honoured only when the named source is usable. A forced request is always honoured when the index is in range. A clear command returns the block to automatic selection.

The controller is a three-state machine:
- AUTO: the automatic rules decide.
- MANUAL: the operator target is held.
- FORCED: the operator target is held unconditionally.

Its transitions are:
- TAKE_FORCE: any state to FORCED, on an in-range forced request.
- TAKE_MANUAL: any state to MANUAL, on an accepted manual request.
- RELEASE: MANUAL or FORCED to AUTO, on clear.
- DROP: MANUAL to AUTO, when the held target stops being usable.
- HOLD: stay in the current state when none of the above applies.

Top module: `ref_clk_selector`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, sel_idx equals the oscillator index N-1 (6 by default), sel_change is 0 and sel_ql is 0.
- R2: In mode 2'b00 (priority-only), the block picks the valid external or line source with the numerically lowest priority. The quality code is ignored, so code 4'hF is selectable.
- R3: In mode 2'b01 (quality-first), the block picks the usable source with the lowest rank. The rank of quality code q is rank_tbl[4q+3:4q]. Equal ranks are decided by the lower priority number.
- R4: Candidates still equal after rank and priority are decided by the lowest source index.
- R5: In modes 2'b01, 2'b10 and 2'b11, a source with quality code 4'hF (do-not-use) is never chosen automatically.
- R6: In modes 2'b10 and 2'b11 (extended), a source whose identifier nibble (status bits [7:4]) equals own_id is treated as do-not-use. Otherwise selection follows R3.
- R7: The oscillator (index N-1) is chosen automatically only when no external or line source is usable. The oscillator is always usable.
- R8: A cmd_manual pulse naming a usable source moves the block to MANUAL on that source, regardless of priority or rank. A pulse naming an invalid, do-not-use or out-of-range source is rejected, and both state and selection are kept.
- R9: In MANUAL, if the held source becomes unusable, the block returns to AUTO in that same decision.
- R10: A cmd_force pulse with an in-range index moves the block to FORCED on that source, even when the source is invalid or do-not-use. The block holds that source until the next command.
- R11: cmd_clear returns the block to AUTO. When commands coincide, force wins over manual and manual wins over clear. A forced request with an index of N or above is ignored.
- R12: The outputs are registered one cycle after the inputs. sel_change is 1 for exactly the cycles in which sel_idx differs from its previous value. sel_ql is bits [3:0] of the chosen source's status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Selection rule: 00 priority, 01 quality, 1x extended |
| own_id | input | 4 | Identifier of this node |
| rank_tbl | input | 64 | Rank of each quality code, 4 bits per code |
| src_valid | input | N | Per-source valid flag (bit N-1 is unused; the oscillator is always usable) |
| src_prio | input | N*PRIO_W | Per-source priority, lower number wins |
| src_stat | input | N*8 | Per-source status byte: identifier [7:4], quality [3:0] |
| cmd_manual | input | 1 | Manual switchover request |
| cmd_force | input | 1 | Forced switchover request |
| cmd_clear | input | 1 | Return to automatic selection |
| cmd_sel | input | IW | Source index named by a command |
| sel_idx | output | IW | Chosen source index |
| sel_change | output | 1 | One-cycle strobe when sel_idx changes |
| sel_ql | output | 4 | Quality code of the chosen source |

## Verification
Two functions can land in the same decision:
- A command arriving together with a change to a source's usability. This is provoked by pulsing force and manual together, and manual together with clear, while the held source is still usable.
- A held manual target losing its valid flag in the same cycle that the automatic winner moves.

The bench runs a behavioural model of the precedence and the fallback, and compares all three outputs with it after every edge. A long stretch of random commands and source changes makes these coincidences recur.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
    typedef enum logic [1:0] {
        ST_AUTO   = 2'd0,
        ST_MANUAL = 2'd1,
        ST_FORCED = 2'd2
    } rcs_state_e;

    localparam logic [3:0] QL_DNU     = 4'hF;
    localparam logic [1:0] MODE_PRIO  = 2'b00;
    localparam logic [1:0] MODE_QUAL  = 2'b01;
endpackage

// File: rtl/rcs_qualify.sv
module rcs_qualify #(
    parameter int N = 7
) (
    input  logic [1:0]     mode,
    input  logic [3:0]     own_id,
    input  logic [63:0]    rank_tbl,
    input  logic [N-1:0]   src_valid,
    input  logic [N*8-1:0] src_stat,
    output logic [N-1:0]   usable,
    output logic [N*4-1:0] rank_flat
);
    import rcs_pkg::*;

    logic qual_on;
    logic ext_on;
    assign qual_on = (mode != MODE_PRIO);
    assign ext_on  = mode[1];

    for (genvar i = 0; i < N; i++) begin : g_src
        logic [3:0] ql;
        logic [3:0] sid;
        assign ql  = src_stat[i*8 +: 4];
        assign sid = src_stat[i*8+4 +: 4];
        assign rank_flat[i*4 +: 4] = rank_tbl[ql*4 +: 4];
        if (i == N-1) begin : g_osc
            assign usable[i] = 1'b1;
        end else begin : g_line
            logic dnu;
            assign dnu = (ql == QL_DNU) || (ext_on && (sid == own_id));
            assign usable[i] = src_valid[i] && !(qual_on && dnu);
        end
    end
endmodule

// File: rtl/rcs_arbiter.sv
module rcs_arbiter #(
    parameter int N      = 7,
    parameter int PRIO_W = 4,
    localparam int IW    = $clog2(N)
) (
    input  logic              qual_on,
    input  logic [N-1:0]      usable,
    input  logic [N*4-1:0]    rank_flat,
    input  logic [N*PRIO_W-1:0] prio_flat,
    output logic [IW-1:0]     best_idx,
    output logic              any_line
);
    localparam int KW = 4 + PRIO_W;

    logic [KW-1:0] best_key;
    logic [KW-1:0] key;

    always_comb begin
        best_idx = IW'(N-1);
        best_key = '1;
        any_line = 1'b0;
        key      = '0;
        for (int i = 0; i < N-1; i++) begin
            key = {(qual_on ? rank_flat[i*4 +: 4] : 4'd0), prio_flat[i*PRIO_W +: PRIO_W]};
            if (usable[i] && (!any_line || key < best_key)) begin
                best_key = key;
                best_idx = IW'(i);
                any_line = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ref_clk_selector.sv
module ref_clk_selector #(
    parameter int NUM_LINE = 4,
    parameter int PRIO_W   = 4,
    localparam int N       = NUM_LINE + 3,
    localparam int IW      = $clog2(N)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          mode,
    input  logic [3:0]          own_id,
    input  logic [63:0]         rank_tbl,
    input  logic [N-1:0]        src_valid,
    input  logic [N*PRIO_W-1:0] src_prio,
    input  logic [N*8-1:0]      src_stat,
    input  logic                cmd_manual,
    input  logic                cmd_force,
    input  logic                cmd_clear,
    input  logic [IW-1:0]       cmd_sel,
    output logic [IW-1:0]       sel_idx,
    output logic                sel_change,
    output logic [3:0]          sel_ql
);
    import rcs_pkg::*;

    localparam int NP = 1 << IW;
    localparam logic [IW-1:0] OSC = IW'(N-1);

    logic [N-1:0]   usable;
    logic [N*4-1:0] rank_flat;
    logic [IW-1:0]  auto_idx;
    logic           any_line;
    logic [NP-1:0]  usable_pad;

    rcs_state_e     state, state_nx;
    logic [IW-1:0]  tgt, tgt_nx, sel_nx;
    logic [3:0]     ql_nx;
    logic           in_range, force_ok, manual_ok;

    rcs_qualify #(.N(N)) u_qualify (
        .mode      (mode),
        .own_id    (own_id),
        .rank_tbl  (rank_tbl),
        .src_valid (src_valid),
        .src_stat  (src_stat),
        .usable    (usable),
        .rank_flat (rank_flat)
    );

    rcs_arbiter #(.N(N), .PRIO_W(PRIO_W)) u_arbiter (
        .qual_on   (mode != MODE_PRIO),
        .usable    (usable),
        .rank_flat (rank_flat),
        .prio_flat (src_prio),
        .best_idx  (auto_idx),
        .any_line  (any_line)
    );

    assign usable_pad = NP'(usable);
    assign in_range   = (int'(cmd_sel) < N);
    assign force_ok   = cmd_force && in_range;
    assign manual_ok  = cmd_manual && in_range && usable_pad[cmd_sel];

    // transitions: TAKE_FORCE, TAKE_MANUAL, RELEASE, DROP, HOLD
    always_comb begin
        state_nx = state;
        tgt_nx   = tgt;
        if (force_ok) begin
            state_nx = ST_FORCED;
            tgt_nx   = cmd_sel;
        end else if (manual_ok) begin
            state_nx = ST_MANUAL;
            tgt_nx   = cmd_sel;
        end else begin
            unique case (state)
                ST_AUTO:   state_nx = ST_AUTO;
                ST_MANUAL: if (cmd_clear || !usable_pad[tgt]) state_nx = ST_AUTO;
                ST_FORCED: if (cmd_clear) state_nx = ST_AUTO;
                default:   state_nx = ST_AUTO;
            endcase
        end
    end

    always_comb begin
        sel_nx = (state_nx == ST_AUTO) ? auto_idx : tgt_nx;
        ql_nx  = 4'd0;
        for (int i = 0; i < N; i++) begin
            if (sel_nx == IW'(i)) ql_nx = src_stat[i*8 +: 4];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_AUTO;
            tgt   <= OSC;
        end else begin
            state <= state_nx;
            tgt   <= tgt_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_idx    <= OSC;
            sel_change <= 1'b0;
            sel_ql     <= 4'd0;
        end else begin
            sel_idx    <= sel_nx;
            sel_change <= (sel_nx != sel_idx);
            sel_ql     <= ql_nx;
        end
    end

    assert_chg_marks_move_R12: assert property (@(posedge clk) disable iff (!rst_n)
        sel_change == (sel_idx != $past(sel_idx)));

    assert_force_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FORCED && !cmd_force && !cmd_manual && !cmd_clear)
        |=> (state == ST_FORCED && $stable(sel_idx)));

    assert_manual_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MANUAL && cmd_manual && !cmd_force && !cmd_clear
         && !manual_ok && usable_pad[tgt]) |=> $stable(sel_idx));

    assert_auto_no_dnu_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_AUTO && sel_idx != OSC && $past(mode) != MODE_PRIO)
        |-> sel_ql != QL_DNU);

    assert_osc_last_resort_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_AUTO && sel_change && sel_idx == OSC) |-> !$past(any_line));
endmodule

// File: tb/test_ref_clk_selector.sv
module test_ref_clk_selector;
    localparam int NL = 4;
    localparam int PW = 4;
    localparam int N  = NL + 3;
    localparam int IW = $clog2(N);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0]      mode = 2'b00;
    logic [3:0]      own_id = 4'd5;
    logic [63:0]     rank_tbl;
    logic [N-1:0]    src_valid = '0;
    logic [N*PW-1:0] src_prio = '1;
    logic [N*8-1:0]  src_stat = '0;
    logic cmd_manual = 1'b0, cmd_force = 1'b0, cmd_clear = 1'b0;
    logic [IW-1:0] cmd_sel = '0;
    logic [IW-1:0] sel_idx;
    logic sel_change;
    logic [3:0] sel_ql;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    string cur_req = "R1";

    int m_state = 0, m_tgt = N-1, m_sel = N-1, m_chg = 0, m_ql = 0;
    bit model_on = 0;

    always #10 clk = ~clk;

    ref_clk_selector #(.NUM_LINE(NL), .PRIO_W(PW)) i_ref_clk_selector (
        .clk(clk), .rst_n(rst_n), .mode(mode), .own_id(own_id), .rank_tbl(rank_tbl),
        .src_valid(src_valid), .src_prio(src_prio), .src_stat(src_stat),
        .cmd_manual(cmd_manual), .cmd_force(cmd_force), .cmd_clear(cmd_clear),
        .cmd_sel(cmd_sel), .sel_idx(sel_idx), .sel_change(sel_change), .sel_ql(sel_ql)
    );

    task automatic chk(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    function automatic bit m_usable(int i);
        int q, id;
        if (i == N-1) return 1;
        if (i >= N) return 0;
        q  = int'(src_stat[i*8 +: 4]);
        id = int'(src_stat[i*8+4 +: 4]);
        if (!src_valid[i]) return 0;
        if (mode != 2'b00 && q == 15) return 0;
        if (mode[1] && id == int'(own_id)) return 0;
        return 1;
    endfunction

    function automatic int m_auto();
        int best = N-1;
        int bk = 0;
        for (int i = 0; i < N-1; i++) begin
            int k;
            k = int'(src_prio[i*PW +: PW]);
            if (mode != 2'b00) k = k + 16 * int'(rank_tbl[int'(src_stat[i*8 +: 4])*4 +: 4]);
            if (m_usable(i) && (best == N-1 || k < bk)) begin
                best = i;
                bk = k;
            end
        end
        return best;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state = 0; m_tgt = N-1; m_sel = N-1; m_chg = 0; m_ql = 0;
        end else begin
            int s, nx;
            s = int'(cmd_sel);
            if (cmd_force && s < N) begin
                m_state = 2; m_tgt = s;
            end else if (cmd_manual && m_usable(s)) begin
                m_state = 1; m_tgt = s;
            end else if (cmd_clear) begin
                m_state = 0;
            end else if (m_state == 1 && !m_usable(m_tgt)) begin
                m_state = 0;
            end
            nx = (m_state == 0) ? m_auto() : m_tgt;
            m_chg = (nx != m_sel) ? 1 : 0;
            m_sel = nx;
            m_ql = int'(src_stat[nx*8 +: 4]);
        end
    end

    always @(negedge clk) begin
        if (model_on) begin
            chk(cur_req, int'(sel_idx), m_sel, "model sel_idx");
            chk(cur_req, int'(sel_change), m_chg, "model sel_change (R12)");
            chk(cur_req, int'(sel_ql), m_ql, "model sel_ql (R12)");
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            errors++;
            $display("FAIL watchdog R12 actual %0d cycles expected completion", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic set_src(int i, bit v, int p, int id, int q);
        src_valid[i] = v;
        src_prio[i*PW +: PW] = PW'(p);
        src_stat[i*8 +: 8] = {4'(id), 4'(q)};
    endtask

    task automatic clr_all();
        for (int i = 0; i < N; i++) set_src(i, 0, 15, 0, 0);
    endtask

    task automatic settle();
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic cmd(bit f, bit m, bit c, int s);
        cmd_force = f; cmd_manual = m; cmd_clear = c; cmd_sel = IW'(s);
        @(negedge clk);
        cmd_force = 0; cmd_manual = 0; cmd_clear = 0;
        @(negedge clk);
    endtask

    task automatic ident_tbl();
        for (int q = 0; q < 16; q++) rank_tbl[q*4 +: 4] = 4'(q);
    endtask

    initial begin
        ident_tbl();
        clr_all();
        repeat (3) @(negedge clk);
        cur_req = "R1";
        chk("R1", int'(sel_idx), N-1, "reset sel_idx");
        chk("R1", int'(sel_change), 0, "reset sel_change");
        chk("R1", int'(sel_ql), 0, "reset sel_ql");
        rst_n = 1'b1;
        model_on = 1;
        @(negedge clk);
        chk("R1", int'(sel_idx), N-1, "first cycle sel_idx");

        cur_req = "R7";
        mode = 2'b01;
        set_src(0, 1, 0, 0, 15); set_src(2, 1, 0, 0, 15);
        settle();
        chk("R7", int'(sel_idx), 6, "all DNU -> oscillator");

        cur_req = "R2";
        clr_all(); mode = 2'b00;
        set_src(0, 1, 3, 0, 15); set_src(2, 1, 1, 0, 2); set_src(4, 1, 2, 0, 1);
        settle();
        chk("R2", int'(sel_idx), 2, "lowest priority number");
        set_src(2, 1, 1, 0, 15);
        settle();
        chk("R2", int'(sel_idx), 2, "quality ignored in priority mode");
        chk("R12", int'(sel_ql), 15, "ql of chosen");

        cur_req = "R3";
        clr_all(); mode = 2'b01;
        set_src(0, 1, 9, 0, 1); set_src(2, 1, 0, 0, 3); set_src(4, 1, 4, 0, 1);
        settle();
        chk("R3", int'(sel_idx), 4, "rank tie broken by priority");
        for (int q = 0; q < 16; q++) rank_tbl[q*4 +: 4] = 4'(15 - q);
        settle();
        chk("R3", int'(sel_idx), 2, "rank table reorders");
        ident_tbl();

        cur_req = "R4";
        clr_all();
        set_src(3, 1, 5, 0, 2); set_src(1, 1, 5, 0, 2);
        settle();
        chk("R4", int'(sel_idx), 1, "lowest index on full tie");

        cur_req = "R5";
        clr_all();
        set_src(1, 1, 0, 0, 15); set_src(3, 1, 9, 0, 4);
        settle();
        chk("R5", int'(sel_idx), 3, "DNU skipped");

        cur_req = "R6";
        clr_all(); mode = 2'b10;
        set_src(1, 1, 0, 5, 1); set_src(3, 1, 0, 6, 2);
        settle();
        chk("R6", int'(sel_idx), 3, "own identifier rejected");
        mode = 2'b01;
        settle();
        chk("R6", int'(sel_idx), 1, "identifier ignored in quality mode");

        cur_req = "R8";
        clr_all();
        set_src(1, 1, 0, 0, 1); set_src(3, 1, 0, 0, 4);
        settle();
        cmd(0, 1, 0, 3);
        chk("R8", int'(sel_idx), 3, "manual accepted");
        cmd(0, 1, 0, 5);
        chk("R8", int'(sel_idx), 3, "manual to invalid rejected");

        cur_req = "R9";
        src_valid[3] = 0;
        settle();
        chk("R9", int'(sel_idx), 1, "manual target lost -> auto");

        cur_req = "R10";
        cmd(1, 0, 0, 5);
        chk("R10", int'(sel_idx), 5, "forced to invalid source");
        set_src(2, 1, 0, 0, 0);
        settle();
        chk("R10", int'(sel_idx), 5, "forced held");

        cur_req = "R11";
        cmd(0, 0, 1, 0);
        chk("R11", int'(sel_idx), 2, "clear -> auto");
        cmd(1, 0, 0, 7);
        chk("R11", int'(sel_idx), 2, "out-of-range force ignored");
        cmd(1, 1, 0, 4);
        chk("R11", int'(sel_idx), 4, "force beats manual");
        cmd_force = 0; cmd_manual = 1; cmd_clear = 1; cmd_sel = 3'd1;
        @(negedge clk);
        cmd_manual = 0; cmd_clear = 0;
        chk("R11", int'(sel_idx), 1, "manual beats clear");
        chk("R12", int'(sel_change), 1, "strobe on move");
        @(negedge clk);
        chk("R12", int'(sel_change), 0, "strobe one cycle");
        cmd(0, 0, 1, 0);

        cur_req = "R12";
        for (int k = 0; k < 600; k++) begin
            int r;
            r = int'($urandom % 16);
            mode = 2'($urandom);
            if (r < 6) set_src(int'($urandom % (N-1)), 1'($urandom),
                               int'($urandom % 4), int'($urandom % 8), int'($urandom % 16));
            cmd_force  = (r == 6);
            cmd_manual = (r == 7 || r == 8);
            cmd_clear  = (r == 8 || r == 9);
            cmd_sel    = IW'($urandom);
            @(negedge clk);
        end
        cmd_force = 0; cmd_manual = 0; cmd_clear = 0;
        settle();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule